// File: doc/BRIEF.md
# Memory Interface Training Sequencer

This block holds one control and status word that software uses to run memory interface training. A single write picks which training types to run, which ranks each rank-qualified type covers, and asks for a run to begin. The sequencer then works through the selected work in a fixed order. For each job it sends a one-cycle start pulse to that type's training engine, along with the rank index, and waits for the engine's done before it moves on. When no work remains it raises a read-only done flag inside the same word. Software polls that flag.

There are six training types, numbered as engine indices 0 to 5. In run order they are: command bus training (0), write leveling (1), gate training (2), read DQ training (3), write DQ training (4) and write-leveling calibration (5). Types 1 to 4 are rank-qualified, each with a two-bit rank mask. Types 0 and 5 run once, on rank 0. Some fields carry enables for frequency-change retraining and periodic retraining of gate and write training. Those fields are stored and read back only. They never affect a run. The engines themselves are stubs outside this block.

Top module: `mem_train_sched`

## Requirements
- R1: After synchronous reset the control word reads as zero, and no engine start is driven.
- R2: A write accepted while idle stores bits [23:2] and reads them back unchanged. Bits 31 to 24 always read as zero, and writes to them are ignored.
- R3: Bit 1 (done) is read-only: the written value of bit 1 never changes it. A write to an idle block with bit 0 clear starts nothing and leaves done as it was.
- R4: While idle, a write with bit 0 set starts a run. On the next cycle bit 0 reads 1 (busy) and bit 1 reads 0. Bit 0 stays 1 until the run ends.
- R5: The type enables sit at bits 2 to 7, for engine indices 0 to 5 in order. Enabled types run strictly in ascending engine index.
- R6: The rank masks sit at [9:8] for index 1, [11:10] for index 2, [13:12] for index 3 and [15:14] for index 4. A mask's bit r selects rank r. Within a type, ranks run lowest first. Indices 0 and 5 run once, with rank 0.
- R7: A type with a clear enable bit is skipped. A rank-qualified type with a zero mask is also skipped.
- R8: Each start is a one-hot pulse of exactly one cycle. The next start comes only after the done of the engine currently running. A done from any other engine is ignored.
- R9: Done reads 1 and busy reads 0 starting one cycle after the clock edge that sampled the last engine done. A run with no work sets done one cycle after the starting write.
- R10: A write made while a run is in progress is ignored: the stored fields are unchanged, and the run's sequence is unaffected.
- R11: The stored-only retraining fields at bits [23:16] have no effect on which engines start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Write strobe for the control word |
| reg_wr_data | input | DATA_W | Write data |
| reg_rd_data | output | DATA_W | Current control and status word |
| eng_start | output | 6 | One-hot start pulse, one bit per training engine |
| eng_rank | output | 1 | Rank index that goes with the start pulse |
| eng_done | input | 6 | Completion strobe from each training engine |

## Verification
The bench builds the block with its defaults: a 32-bit word, six training types and two ranks. That gives only twelve type/rank job slots. At this size every combination of the six type enables can be swept against four rotated rank-mask patterns, so each skip rule, rank order and empty run is covered. Mixed engine latencies, stray done strobes from idle engines and random words with the upper bits set fill in the rest. A write landed in the middle of a run shows that busy writes are ignored.

// File: rtl/mts_pkg.sv
package mts_pkg;

    localparam int NUM_TYPES    = 6;
    localparam int NUM_RANKS    = 2;
    localparam int FIRST_RANKED = 1;
    localparam int NUM_RANKED   = 4;
    localparam int NUM_JOBS     = NUM_TYPES * NUM_RANKS;
    localparam int POS_W        = $clog2(NUM_JOBS + 1);
    localparam int TYPE_IDX_W   = $clog2(NUM_TYPES);
    localparam int RANK_IDX_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1;

    localparam int BIT_BUSY = 0;
    localparam int BIT_DONE = 1;
    localparam int CFG_LSB  = 2;

    typedef enum logic [TYPE_IDX_W-1:0] {
        TT_CMD_BUS  = 3'd0,
        TT_WR_LEVEL = 3'd1,
        TT_GATE     = 3'd2,
        TT_READ     = 3'd3,
        TT_WRITE    = 3'd4,
        TT_WL_CAL   = 3'd5
    } train_type_e;

    typedef struct packed {
        logic [1:0][1:0]                          periodic_en;
        logic [1:0][1:0]                          dvfs_en;
        logic [NUM_RANKED-1:0][NUM_RANKS-1:0]     rank_mask;
        logic [NUM_TYPES-1:0]                     type_en;
    } train_cfg_t;

    localparam int CFG_W   = $bits(train_cfg_t);
    localparam int CFG_MSB = CFG_LSB + CFG_W - 1;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic                   valid;
        logic [POS_W-1:0]       pos;
        logic [TYPE_IDX_W-1:0]  ttype;
        logic [RANK_IDX_W-1:0]  rank;
    } job_pick_t;

endpackage

// File: rtl/mts_ctrl_reg.sv
module mts_ctrl_reg
    import mts_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              busy,
    input  logic              run_done,
    output logic              start_req,
    output train_cfg_t        cfg,
    output logic [DATA_W-1:0] rd_data
);

    logic       done_q;
    logic       accept;
    train_cfg_t cfg_q;
    logic       wr_unused_bits;

    assign wr_unused_bits = ^{wr_data[BIT_DONE], wr_data[DATA_W-1:CFG_MSB+1]};

    assign accept    = wr_en && !busy;
    assign start_req = accept && wr_data[BIT_BUSY];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            done_q <= 1'b0;
        end else begin
            if (accept) begin
                cfg_q <= train_cfg_t'(wr_data[CFG_MSB:CFG_LSB]);
            end
            if (start_req) begin
                done_q <= 1'b0;
            end else if (run_done) begin
                done_q <= 1'b1;
            end
        end
    end

    assign cfg = cfg_q;

    always_comb begin
        rd_data                  = '0;
        rd_data[CFG_MSB:CFG_LSB] = cfg_q;
        rd_data[BIT_DONE]        = done_q;
        rd_data[BIT_BUSY]        = busy;
    end

endmodule

// File: rtl/mts_job_picker.sv
module mts_job_picker
    import mts_pkg::*;
(
    input  train_cfg_t       cfg,
    input  logic [POS_W-1:0] cursor,
    output job_pick_t        pick
);

    logic [NUM_JOBS-1:0] job_en;

    for (genvar g = 0; g < NUM_JOBS; g++) begin : g_slot
        localparam int T = g / NUM_RANKS;
        localparam int R = g % NUM_RANKS;
        if (T >= FIRST_RANKED && T < FIRST_RANKED + NUM_RANKED) begin : g_ranked
            assign job_en[g] = cfg.type_en[T] && cfg.rank_mask[T-FIRST_RANKED][R];
        end else if (R == 0) begin : g_single
            assign job_en[g] = cfg.type_en[T];
        end else begin : g_none
            assign job_en[g] = 1'b0;
        end
    end

    always_comb begin
        pick = '0;
        for (int i = NUM_JOBS - 1; i >= 0; i--) begin
            if (job_en[i] && (POS_W'(i) >= cursor)) begin
                pick.valid = 1'b1;
                pick.pos   = POS_W'(i);
                pick.ttype = TYPE_IDX_W'(i / NUM_RANKS);
                pick.rank  = RANK_IDX_W'(i % NUM_RANKS);
            end
        end
    end

endmodule

// File: rtl/mts_sequencer.sv
module mts_sequencer
    import mts_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   start_req,
    input  job_pick_t              pick,
    input  logic [NUM_TYPES-1:0]   eng_done,
    output logic [POS_W-1:0]       cursor,
    output logic                   busy,
    output logic                   run_done,
    output logic [NUM_TYPES-1:0]   eng_start,
    output logic [RANK_IDX_W-1:0]  eng_rank
);

    seq_state_e               state_q;
    logic [POS_W-1:0]         cursor_q;
    logic [TYPE_IDX_W-1:0]    cur_type_q;
    logic [NUM_TYPES-1:0]     start_q;
    logic [RANK_IDX_W-1:0]    rank_q;

    assign run_done = (state_q == SQ_ISSUE) && !pick.valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SQ_IDLE;
            cursor_q   <= '0;
            cur_type_q <= '0;
            start_q    <= '0;
            rank_q     <= '0;
        end else begin
            start_q <= '0;
            unique case (state_q)
                SQ_IDLE: begin
                    if (start_req) begin
                        state_q  <= SQ_ISSUE;
                        cursor_q <= '0;
                    end
                end
                SQ_ISSUE: begin
                    if (pick.valid) begin
                        start_q    <= NUM_TYPES'(1) << pick.ttype;
                        rank_q     <= pick.rank;
                        cur_type_q <= pick.ttype;
                        cursor_q   <= pick.pos + POS_W'(1);
                        state_q    <= SQ_WAIT;
                    end else begin
                        state_q <= SQ_IDLE;
                    end
                end
                SQ_WAIT: begin
                    if (eng_done[cur_type_q]) begin
                        state_q <= SQ_ISSUE;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign cursor    = cursor_q;
    assign busy      = (state_q != SQ_IDLE);
    assign eng_start = start_q;
    assign eng_rank  = rank_q;

endmodule

// File: rtl/mem_train_sched.sv
module mem_train_sched
    import mts_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   reg_wr_en,
    input  logic [DATA_W-1:0]      reg_wr_data,
    output logic [DATA_W-1:0]      reg_rd_data,
    output logic [NUM_TYPES-1:0]   eng_start,
    output logic [RANK_IDX_W-1:0]  eng_rank,
    input  logic [NUM_TYPES-1:0]   eng_done
);

    train_cfg_t        cfg;
    job_pick_t         pick;
    logic [POS_W-1:0]  cursor;
    logic              busy;
    logic              run_done;
    logic              start_req;

    mts_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (reg_wr_en),
        .wr_data   (reg_wr_data),
        .busy      (busy),
        .run_done  (run_done),
        .start_req (start_req),
        .cfg       (cfg),
        .rd_data   (reg_rd_data)
    );

    mts_job_picker u_pick (
        .cfg    (cfg),
        .cursor (cursor),
        .pick   (pick)
    );

    mts_sequencer u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_req (start_req),
        .pick      (pick),
        .eng_done  (eng_done),
        .cursor    (cursor),
        .busy      (busy),
        .run_done  (run_done),
        .eng_start (eng_start),
        .eng_rank  (eng_rank)
    );

endmodule

// File: rtl/mts_checker.sv
module mts_checker
    import mts_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  reg_wr_en,
    input logic [DATA_W-1:0]     reg_wr_data,
    input logic [DATA_W-1:0]     reg_rd_data,
    input logic [NUM_TYPES-1:0]  eng_start
);

    AST_START_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(eng_start)); // R8

    AST_START_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (|eng_start) |=> (eng_start == '0)); // R8

    AST_START_ONLY_BUSY: assert property (@(posedge clk) disable iff (rst)
        (|eng_start) |-> reg_rd_data[BIT_BUSY]); // R4

    AST_HIGH_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        reg_rd_data[DATA_W-1:CFG_MSB+1] == '0); // R2

    AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_rd_data[BIT_BUSY]) |=> $stable(reg_rd_data[CFG_MSB:CFG_LSB])); // R10

    AST_START_CLEARS_DONE: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_en && reg_wr_data[BIT_BUSY] && !reg_rd_data[BIT_BUSY])
        |=> (reg_rd_data[BIT_BUSY] && !reg_rd_data[BIT_DONE])); // R4

    AST_DONE_ENDS_RUN: assert property (@(posedge clk) disable iff (rst)
        $rose(reg_rd_data[BIT_DONE]) |-> (!reg_rd_data[BIT_BUSY] && eng_start == '0)); // R9

endmodule

bind mem_train_sched mts_checker #(.DATA_W(DATA_W)) u_mts_chk (
    .clk         (clk),
    .rst         (rst),
    .reg_wr_en   (reg_wr_en),
    .reg_wr_data (reg_wr_data),
    .reg_rd_data (reg_rd_data),
    .eng_start   (eng_start)
);

// File: tb/mem_train_sched_tb.sv
module mem_train_sched_tb;

    localparam int DW = 32;
    localparam int NT = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          reg_wr_en = 1'b0;
    logic [DW-1:0] reg_wr_data = '0;
    logic [DW-1:0] reg_rd_data;
    logic [NT-1:0] eng_start;
    logic [0:0]    eng_rank;
    logic [NT-1:0] eng_done = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    mem_train_sched #(.DATA_W(DW)) u_dut (
        .clk         (clk),
        .rst         (rst),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_data (reg_rd_data),
        .eng_start   (eng_start),
        .eng_rank    (eng_rank),
        .eng_done    (eng_done)
    );

    task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", req, act, exp, $time);
        end
    endtask

    function automatic logic [DW-1:0] stored_view(input logic [DW-1:0] w);
        return w & 32'h00FF_FFFC;
    endfunction

    // Runs one word; expected job list built from the bit layout in R5/R6/R7.
    task automatic run_word(input logic [DW-1:0] w, input int lat, input bit poke);
        int exp_t[12];
        int exp_r[12];
        int n = 0;
        for (int t = 0; t < NT; t++) begin
            if (w[2+t]) begin
                if (t >= 1 && t <= 4) begin
                    for (int r = 0; r < 2; r++)
                        if (w[8 + 2*(t-1) + r]) begin exp_t[n] = t; exp_r[n] = r; n++; end
                end else begin
                    exp_t[n] = t; exp_r[n] = 0; n++;
                end
            end
        end
        @(negedge clk);
        reg_wr_en = 1'b1; reg_wr_data = w | 32'h1;
        @(negedge clk);
        reg_wr_en = 1'b0;
        check(reg_rd_data[0] == 1'b1 && reg_rd_data[1] == 1'b0, "R4 busy set, done cleared",
              reg_rd_data, stored_view(w) | 32'h1);
        for (int k = 0; k < n; k++) begin
            logic [NT-1:0] oh;
            oh = NT'(1) << exp_t[k];
            @(negedge clk);
            check(eng_start == oh, "R5 R7 start order", DW'(eng_start), DW'(oh));
            check(eng_rank == 1'(exp_r[k]), "R6 rank order", DW'(eng_rank), DW'(exp_r[k]));
            eng_done = ~oh;
            if (poke && k == 0) begin
                reg_wr_en = 1'b1; reg_wr_data = ~w | 32'h1;
            end
            @(negedge clk);
            eng_done = '0; reg_wr_en = 1'b0;
            check(eng_start == '0, "R8 pulse width / stray done ignored", DW'(eng_start), 0);
            for (int d = 0; d < lat; d++) begin
                @(negedge clk);
                check(eng_start == '0, "R8 waits for engine done", DW'(eng_start), 0);
            end
            eng_done = oh;
            @(negedge clk);
            eng_done = '0;
            check(reg_rd_data[1:0] == 2'b01, "R9 still busy right after done edge",
                  DW'(reg_rd_data[1:0]), 32'h1);
        end
        @(negedge clk);
        check(reg_rd_data[1:0] == 2'b10, "R9 done timing", DW'(reg_rd_data[1:0]), 32'h2);
        check(eng_start == '0, "R9 no start after last job", DW'(eng_start), 0);
        check(reg_rd_data == (stored_view(w) | 32'h2), "R2 R10 R11 readback",
              reg_rd_data, stored_view(w) | 32'h2);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(reg_rd_data == '0, "R1 reset word", reg_rd_data, 0);
        check(eng_start == '0, "R1 reset start", DW'(eng_start), 0);

        // R3: bit 1 written high does not set done; bit 0 clear starts nothing
        reg_wr_en = 1'b1; reg_wr_data = 32'hFF00_0106;
        @(negedge clk);
        reg_wr_en = 1'b0;
        check(reg_rd_data == 32'h0000_0104, "R3 R2 idle write", reg_rd_data, 32'h0000_0104);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(eng_start == '0 && reg_rd_data[0] == 1'b0, "R3 no run without bit 0",
                  DW'(eng_start), 0);
        end

        run_word(32'h0000_0000, 0, 0); // R9 empty run
        // R3: idle write with bit 1 clear keeps done
        reg_wr_en = 1'b1; reg_wr_data = 32'h0000_0010;
        @(negedge clk);
        reg_wr_en = 1'b0;
        check(reg_rd_data == 32'h0000_0012, "R3 done is read-only", reg_rd_data, 32'h0000_0012);

        // Sweep of all type enables against rotated rank masks (R5 R6 R7 R11)
        for (int te = 0; te < 64; te++) begin
            for (int m = 0; m < 4; m++) begin
                logic [DW-1:0] w;
                w = DW'(te) << 2;
                for (int j = 0; j < 4; j++) w[8 + 2*j +: 2] = 2'((m + j) % 4);
                w[23:16] = 8'((te * 37 + m * 11) & 8'hFF);
                run_word(w, (te + m) % 3, 0);
            end
        end

        // R10: write during a run is ignored
        run_word(32'h00A5_FFFC, 1, 1);
        run_word(32'h0000_55FC, 2, 1);

        // Random words, upper bits set too (R2)
        for (int i = 0; i < 40; i++) begin
            run_word($urandom, i % 4, i % 5 == 0);
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule